// File: doc/BRIEF.md
# Flash Chip-Erase Command Controller

This block pairs a command decoder with an embedded erase engine for a small word-wide flash-style array that it holds itself. The host drives write cycles made of an address, a data word and a write strobe. A six-write unlock sequence arms a whole-array erase. Once the sixth write is accepted, the engine runs by itself. It first writes zero to every word. It then checks that every word reads back as zero. Last, it sets every word to all ones. When the engine finishes, it drops `busy` and reads return to array data.

While the engine runs, a read returns a status word instead of array data. Bit 7 reads 0. Bits 6 and 2 carry the same toggle value, and that value flips on every status read. Writes made during the operation are discarded. Only the hardware reset input can stop an erase. Reset also returns the array to its reset-time pattern and clears any unlock progress.

Top module: `flash_erase_ctrl`

## Requirements
- R1: An erase starts only after six writes in a row with (address, data) equal to (555h, 00AAh), (2AAh, 0055h), (555h, 0080h), (555h, 00AAh), (2AAh, 0055h), (555h, 0010h). `busy` reads 1 in the cycle after the sixth write is sampled.
- R2: A write whose address or data does not match the expected step sends the decoder back to its first step. A run of writes that contains a mismatch never starts an erase, even if the correct remaining writes follow it.
- R3: Read cycles placed between the unlock writes do not disturb the sequence.
- R4: `busy` stays high for exactly 3 × DEPTH × STEP_CLKS clock cycles. The zero-fill, check and erase phases each spend STEP_CLKS cycles on every word.
- R5: After `busy` falls, every word of the array reads FFFFh.
- R6: A read issued while `busy` is high returns a status word on the next cycle. In that word bit 7 is 0, bits 6 and 2 are equal, and all other bits are 0. The first status read after a start returns 0000h. Each later status read returns the other value of the pair 0000h and 0044h.
- R7: Writes made while `busy` is high are ignored. This holds even for a complete unlock sequence: the busy time does not change and no second erase follows.
- R8: Driving `rst_n` low drops `busy` at once and ends the erase. Reads then return array data. Unlock progress made before the reset is lost.
- R9: After reset, `busy` is 0 and `rdata` is 0000h. Word i holds A5A5h XOR {i[7:0], i[7:0]}. A read returns the addressed word (low address bits) one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data appears on the next cycle |
| addr | input | ADDR_W | Word address for reads and commands |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data or status word |
| busy | output | 1 | High while the embedded erase runs |

## Verification
The checker watches every cycle for five things:
- `busy` rises only on a decoder start.
- The engine phases advance only in the order zero-fill, check, erase, idle.
- Every word is FFFFh at the moment `busy` falls.
- Status reads keep bit 7 low and bits 6 and 2 equal.
- Back-to-back status reads toggle bits 6 and 2.

Only the bench scenarios can show the rest: the exact busy length, that an aborted or broken sequence leaves no side effect, that interleaved reads are tolerated, and that writes made during an erase change nothing.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int SEQ_LEN = 6;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PROG   = 2'd1,
        PH_VERIFY = 2'd2,
        PH_ERASE  = 2'd3
    } phase_e;

    // Expected command address for each unlock step
    function automatic logic [11:0] seq_addr(input logic [2:0] step);
        case (step)
            3'd1, 3'd4: return 12'h2AA;
            default:    return 12'h555;
        endcase
    endfunction

    // Expected command data (low byte) for each unlock step
    function automatic logic [7:0] seq_data(input logic [2:0] step);
        case (step)
            3'd0, 3'd3: return 8'hAA;
            3'd1, 3'd4: return 8'h55;
            3'd2:       return 8'h80;
            default:    return 8'h10;
        endcase
    endfunction

endpackage

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              start
);

    typedef struct packed {
        logic [2:0] step;
    } dec_s;

    dec_s dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        start = 1'b0;
        // writes during an erase never reach the sequence matcher
        if (wr_en && !busy) begin
            if (addr == ADDR_W'(seq_addr(dec_q.step)) &&
                wdata == DATA_W'(seq_data(dec_q.step))) begin
                if (dec_q.step == 3'(SEQ_LEN - 1)) begin
                    start      = 1'b1;
                    dec_d.step = 3'd0;
                end else begin
                    dec_d.step = dec_q.step + 3'd1;
                end
            end else begin
                dec_d.step = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

endmodule

// File: rtl/erase_engine.sv
module erase_engine
    import flash_erase_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 64,
    parameter int STEP_CLKS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DATA_W-1:0]        cur_word,
    output logic                     busy,
    output phase_e                   phase,
    output logic [$clog2(DEPTH)-1:0] idx,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        mem_wdata
);

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int TICK_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [TICK_W-1:0] tick;
    } eng_s;

    eng_s eng_d, eng_q;
    logic advance;

    always_comb begin
        eng_d     = eng_q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        advance   = 1'b0;
        if (eng_q.phase == PH_IDLE) begin
            if (start) begin
                eng_d.phase = PH_PROG;
                eng_d.idx   = '0;
                eng_d.tick  = '0;
            end
        end else if (eng_q.tick == TICK_W'(STEP_CLKS - 1)) begin
            eng_d.tick = '0;
            case (eng_q.phase)
                PH_PROG: begin
                    mem_we  = 1'b1;
                    advance = 1'b1;
                end
                PH_VERIFY: begin
                    // a word that did not read zero is written again
                    if (cur_word != '0) mem_we = 1'b1;
                    else                advance = 1'b1;
                end
                default: begin
                    mem_we    = 1'b1;
                    mem_wdata = '1;
                    advance   = 1'b1;
                end
            endcase
            if (advance) begin
                if (eng_q.idx == IDX_W'(DEPTH - 1)) begin
                    eng_d.idx = '0;
                    case (eng_q.phase)
                        PH_PROG:   eng_d.phase = PH_VERIFY;
                        PH_VERIFY: eng_d.phase = PH_ERASE;
                        default:   eng_d.phase = PH_IDLE;
                    endcase
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                end
            end
        end else begin
            eng_d.tick = eng_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{phase: PH_IDLE, idx: '0, tick: '0};
        else        eng_q <= eng_d;
    end

    assign busy  = (eng_q.phase != PH_IDLE);
    assign phase = eng_q.phase;
    assign idx   = eng_q.idx;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 64,
    parameter int STEP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tog;
    } rd_s;

    logic              start;
    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_s               rd_d, rd_q;

    function automatic logic [DATA_W-1:0] seed_word(input int i);
        return DATA_W'(16'hA5A5 ^ (16'(i) * 16'h0101));
    endfunction

    erase_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .busy  (busy),
        .start (start)
    );

    erase_engine #(.DATA_W(DATA_W), .DEPTH(DEPTH), .STEP_CLKS(STEP_CLKS)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cur_word  (mem_q[idx]),
        .busy      (busy),
        .phase     (phase),
        .idx       (idx),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        mem_d = mem_q;
        if (mem_we) mem_d[idx] = mem_wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            if (busy) begin
                rd_d.rdata    = '0;
                rd_d.rdata[6] = rd_q.tog;
                rd_d.rdata[2] = rd_q.tog;
                rd_d.tog      = ~rd_q.tog;
            end else begin
                rd_d.rdata = mem_q[addr[IDX_W-1:0]];
            end
        end
        if (start) rd_d.tog = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= seed_word(i);
        end else begin
            rd_q  <= rd_d;
            mem_q <= mem_d;
        end
    end

    assign rdata = rd_q.rdata;

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk
    import flash_erase_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              busy,
    input logic [DATA_W-1:0] rdata,
    input logic              start,
    input phase_e            phase,
    input logic [DATA_W-1:0] mem_q [DEPTH]
);

    logic all_ones;
    always_comb begin
        all_ones = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            if (mem_q[i] != '1) all_ones = 1'b0;
    end

    assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_phase_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            (($past(phase) == PH_IDLE)   && (phase == PH_PROG))   ||
            (($past(phase) == PH_PROG)   && (phase == PH_VERIFY)) ||
            (($past(phase) == PH_VERIFY) && (phase == PH_ERASE))  ||
            (($past(phase) == PH_ERASE)  && (phase == PH_IDLE)));

    assert_erased_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> all_ones);

    assert_status_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy)) |-> (!rdata[7] && (rdata[6] == rdata[2])));

    assert_status_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(busy) && $past(rd_en, 2) && $past(busy, 2))
            |-> (rdata[6] != $past(rdata[6])));

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .busy  (busy),
    .rdata (rdata),
    .start (start),
    .phase (phase),
    .mem_q (mem_q)
);

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/1ps
module flash_erase_ctrl_test;

    localparam int DEPTH     = 64;
    localparam int STEP_CLKS = 4;
    localparam int BUSY_LEN  = 3 * DEPTH * STEP_CLKS;
    localparam int NVEC      = 12;

    // {kind[1:0], addr[11:0], value[15:0]}; kind 0 write, 1 read-expect, 2 busy-expect
    localparam logic [29:0] VEC [NVEC] = '{
        {2'd1, 12'h005, 16'hA0A0},  // R9 seed word 5
        {2'd0, 12'h555, 16'h00AA},  // R1
        {2'd0, 12'h2AA, 16'h0055},
        {2'd0, 12'h555, 16'h0080},
        {2'd0, 12'h555, 16'h00AA},
        {2'd0, 12'h2AA, 16'h0055},
        {2'd0, 12'h555, 16'h0010},
        {2'd2, 12'h000, 16'h0001},  // R1 busy
        {2'd1, 12'h000, 16'h0000},  // R6 first status
        {2'd1, 12'h000, 16'h0044},  // R6
        {2'd1, 12'h000, 16'h0000},  // R6
        {2'd2, 12'h000, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int busy_cnt = 0;

    always #10 clk = ~clk;

    flash_erase_ctrl #(.ADDR_W(12), .DATA_W(16), .DEPTH(DEPTH), .STEP_CLKS(STEP_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

    function automatic logic [15:0] exp_seed(input int i);
        logic [7:0] b = 8'(i);
        return 16'hA5A5 ^ {b, b};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic unlock_part(input int first, input int last);
        for (int s = first; s <= last; s++) begin
            case (s)
                0, 3:    wr(12'h555, 16'h00AA);
                1, 4:    wr(12'h2AA, 16'h0055);
                2:       wr(12'h555, 16'h0080);
                default: wr(12'h555, 16'h0010);
            endcase
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy after reset", 32'(busy), 32'd0);
        check("R9 rdata after reset", 32'(rdata), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h000, d); check("R9 word 0", 32'(d), 32'(exp_seed(0)));
        rd(12'h03F, d); check("R9 word 63", 32'(d), 32'(exp_seed(63)));

        // vector table: R1 start, R6 status pattern
        busy_cnt = 0;
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][29:28])
                2'd0: wr(VEC[v][27:16], VEC[v][15:0]);
                2'd1: begin
                    rd(VEC[v][27:16], d);
                    check($sformatf("R1/R6/R9 vector %0d", v), 32'(d), 32'(VEC[v][15:0]));
                end
                default: begin
                    check($sformatf("R1 busy vector %0d", v), 32'(busy), 32'(VEC[v][0]));
                    @(negedge clk);
                end
            endcase
        end
        wait_idle();
        // R4 busy length
        check("R4 busy cycles", 32'(busy_cnt), 32'(BUSY_LEN));
        // R5 all words erased
        for (int i = 0; i < DEPTH; i++) begin
            rd(12'(i), d);
            check($sformatf("R5 word %0d", i), 32'(d), 32'h0000FFFF);
        end

        // R7 writes during busy ignored
        busy_cnt = 0;
        unlock_part(0, 5);
        check("R7 started", 32'(busy), 32'd1);
        unlock_part(0, 5);
        wr(12'h005, 16'h1234);
        wait_idle();
        check("R7 busy cycles unchanged", 32'(busy_cnt), 32'(BUSY_LEN));
        repeat (20) @(negedge clk);
        check("R7 no second erase", 32'(busy), 32'd0);

        // R2 mismatch resets the decoder
        do_reset();
        unlock_part(0, 2);
        wr(12'h555, 16'h00AB);
        unlock_part(4, 5);
        repeat (5) @(negedge clk);
        check("R2 bad data no start", 32'(busy), 32'd0);
        unlock_part(0, 0);
        wr(12'h2AB, 16'h0055);
        unlock_part(2, 5);
        repeat (5) @(negedge clk);
        check("R2 bad address no start", 32'(busy), 32'd0);
        rd(12'h009, d); check("R2 array untouched", 32'(d), 32'(exp_seed(9)));
        unlock_part(0, 5);
        check("R2 full sequence after mismatch", 32'(busy), 32'd1);

        // R8 hardware reset aborts
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 busy drops on reset", 32'(busy), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h00A, d); check("R8 array read after abort", 32'(d), 32'(exp_seed(10)));
        unlock_part(0, 2);
        do_reset();
        unlock_part(3, 5);
        repeat (5) @(negedge clk);
        check("R8 partial sequence discarded", 32'(busy), 32'd0);

        // R3 reads interleaved with unlock writes
        do_reset();
        for (int s = 0; s < 6; s++) begin
            unlock_part(s, s);
            rd(12'(s), d);
        end
        check("R3 start with interleaved reads", 32'(busy), 32'd1);
        wait_idle();
        rd(12'h011, d); check("R3 erase completed", 32'(d), 32'h0000FFFF);

        finish_run();
    end

endmodule